// File: doc/BRIEF.md
# Nap Mode Power Sequencer

This block steers a processor core between full power and a low-power nap state. Software arms nap by setting an enable bit in a configuration word. The sequencer then raises a nap request towards the peripheral logic and waits for that logic to be set up for a low-power state. It also waits until the peripheral buffers are empty and no transaction is outstanding. Only then does it raise a quiesce acknowledge and turn bus snooping off. After a fixed settling delay it gates the core clock.

While the core naps, a free-running time base and a decrementer keep counting. Any of these wake sources brings the core back to full power within four cycles: an interrupt, a machine check, a system-management interrupt, the peripheral side withdrawing the quiesce condition, or decrementer expiry. A hard reset and a soft reset also return the core to full power. A wake source that arrives before acknowledge is raised aborts the entry. Leaving nap, or aborting entry, clears the enable bit, so software has to re-arm nap on purpose.

Top module: `nap_sequencer`

## Requirements
- R1: After the asynchronous reset (`rst_n` low), the outputs are as follows:
  - `state_o` is 0 (FULL_ON) and `nap_en_o` is 0.
  - `quiesce_ack` and `nap_req` are 0.
  - `snoop_en` and `core_clk_en` are 1.
  - `dec_o` is all-ones.
- R2: The nap-enable bit is bit NAP_BIT (9) of `cfg_wdata`. It is written with `cfg_wr` only while `state_o` is FULL_ON, and writes in any other state are ignored. If a write sets the bit, `state_o` becomes REQUEST (1) and `nap_req` rises on the second clock edge after the write. While the bit is 0 the block stays in FULL_ON.
- R3: In REQUEST the block holds until `periph_nap_prog` is 1, then moves to DRAIN_WAIT (2).
- R4: In DRAIN_WAIT the block holds, with `quiesce_ack` low, until `buf_empty` is 1 and `outstanding` is zero.
- R5: When the drain completes, the block moves to ACK_DELAY (3) on the next edge. In ACK_DELAY `quiesce_ack` is 1 and `snoop_en` is 0. After ENTRY_DLY (4) cycles in ACK_DELAY it moves to NAP (4), where `core_clk_en` is 0.
- R6: `quiesce_ack` stays 1 without a break through ACK_DELAY and NAP until a wake source or a reset.
- R7: In NAP, any of `irq`, `mcheck`, `smi`, `periph_release` or decrementer expiry moves the block to WAKE (5) on the next edge. In WAKE, `quiesce_ack` is 0 and `core_clk_en` is 1. After WAKE_CYC cycles the block returns to FULL_ON, with `snoop_en` 1, at most four edges after the edge that sampled the wake source.
- R8: A wake source seen in REQUEST or DRAIN_WAIT returns the block to FULL_ON on the next edge. `quiesce_ack` is never raised in that case.
- R9: Every exit from nap, and every aborted entry, clears the nap-enable bit.
- R10: A synchronous `soft_rst` forces FULL_ON on the next edge, with `quiesce_ack` 0 and the nap-enable bit cleared. It leaves the time base and the decrementer running.
- R11: `tb_o` increases by one on every clock edge in every state, NAP included.
- R12: `dec_o` decreases by one on every edge. A `dec_wr` load of `dec_wdata` is accepted only in FULL_ON. Expiry is the step from 0 to all-ones, and it acts as a wake source on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | CFG_W | Configuration word; bit NAP_BIT is nap enable |
| periph_nap_prog | input | 1 | Peripheral logic set up for a low-power state |
| buf_empty | input | 1 | Peripheral buffers flushed |
| outstanding | input | OUT_W | Count of outstanding peripheral transactions |
| irq | input | 1 | Interrupt wake source |
| mcheck | input | 1 | Machine check wake source |
| smi | input | 1 | System-management interrupt wake source |
| periph_release | input | 1 | Peripheral withdraws quiesce acknowledge |
| dec_wr | input | 1 | Decrementer load strobe |
| dec_wdata | input | DEC_W | Decrementer load value |
| nap_req | output | 1 | Nap request towards peripheral logic |
| quiesce_ack | output | 1 | Quiesce acknowledge |
| snoop_en | output | 1 | Bus snooping enable |
| core_clk_en | output | 1 | Core clock-gate enable |
| state_o | output | 3 | Sequencer state code (0..5) |
| nap_en_o | output | 1 | Current nap-enable bit |
| tb_o | output | TB_W | Time base |
| dec_o | output | DEC_W | Decrementer value |

## Verification
The bench builds the block with ENTRY_DLY of 4 and WAKE_CYC of 3. The largest legal wake length lets the bench measure the four-edge return bound at its limit. The defaults of 32-bit decrementer and 64-bit time base are kept. Loading a small decrementer value brings natural expiry inside nap within a few dozen cycles. The bench also drives each external wake source on its own, and aborts entry at both pre-acknowledge stages.

// File: rtl/nap_pkg.sv
package nap_pkg;
  typedef enum logic [2:0] {
    ST_FULL_ON = 3'd0,
    ST_REQUEST = 3'd1,
    ST_DRAIN   = 3'd2,
    ST_ACK_DLY = 3'd3,
    ST_NAP     = 3'd4,
    ST_WAKE    = 3'd5
  } nap_state_e;
endpackage

// File: rtl/nap_timebase.sv
module nap_timebase #(
  parameter int TB_W  = 64,
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_load,
  input  logic [DEC_W-1:0] dec_load_val,
  output logic [TB_W-1:0]  tb_o,
  output logic [DEC_W-1:0] dec_o,
  output logic             dec_expire_o
);
  localparam logic [TB_W-1:0]  TB_ONE  = TB_W'(1);
  localparam logic [DEC_W-1:0] DEC_ONE = DEC_W'(1);

  logic [TB_W-1:0]  tb_q, tb_d;
  logic [DEC_W-1:0] dec_q, dec_d;
  logic             exp_q, exp_d;

  always_comb begin
    tb_d  = tb_q + TB_ONE;
    exp_d = 1'b0;
    if (dec_load) begin
      dec_d = dec_load_val;
    end else begin
      dec_d = dec_q - DEC_ONE;
      exp_d = (dec_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q  <= '0;
      dec_q <= '1;
      exp_q <= 1'b0;
    end else begin
      tb_q  <= tb_d;
      dec_q <= dec_d;
      exp_q <= exp_d;
    end
  end

  assign tb_o         = tb_q;
  assign dec_o        = dec_q;
  assign dec_expire_o = exp_q;
endmodule

// File: rtl/nap_enable_reg.sv
module nap_enable_reg #(
  parameter int CFG_W   = 32,
  parameter int NAP_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_allowed,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             clear,
  output logic             nap_en_o
);
  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (clear)                    en_d = 1'b0;
    else if (cfg_wr && wr_allowed) en_d = cfg_wdata[NAP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign nap_en_o = en_q;
endmodule

// File: rtl/nap_fsm.sv
module nap_fsm
  import nap_pkg::*;
#(
  parameter int OUT_W     = 4,
  parameter int ENTRY_DLY = 4,
  parameter int WAKE_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             nap_en,
  input  logic             periph_nap_prog,
  input  logic             buf_empty,
  input  logic [OUT_W-1:0] outstanding,
  input  logic             wake,
  output nap_state_e       state_o,
  output logic             clear_en_o
);
  localparam int MAXC  = (ENTRY_DLY > WAKE_CYC) ? ENTRY_DLY : WAKE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_DLY - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  nap_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             drained;

  assign drained = buf_empty && (outstanding == '0);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q + CNT_ONE;
    clear_en_o = 1'b0;
    if (soft_rst) begin
      state_d    = ST_FULL_ON;
      clear_en_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_FULL_ON: if (nap_en && !wake) state_d = ST_REQUEST;
        ST_REQUEST: begin
          if (wake) begin
            state_d    = ST_FULL_ON;
            clear_en_o = 1'b1;
          end else if (periph_nap_prog) begin
            state_d = ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (wake) begin
            state_d    = ST_FULL_ON;
            clear_en_o = 1'b1;
          end else if (drained) begin
            state_d = ST_ACK_DLY;
          end
        end
        ST_ACK_DLY: begin
          if (wake) begin
            state_d    = ST_WAKE;
            clear_en_o = 1'b1;
          end else if (cnt_q == ENTRY_LAST) begin
            state_d = ST_NAP;
          end
        end
        ST_NAP: begin
          if (wake) begin
            state_d    = ST_WAKE;
            clear_en_o = 1'b1;
          end
        end
        ST_WAKE: if (cnt_q == WAKE_LAST) state_d = ST_FULL_ON;
        default: state_d = ST_FULL_ON;
      endcase
    end
    if (state_d != state_q) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FULL_ON;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/nap_sequencer.sv
module nap_sequencer
  import nap_pkg::*;
#(
  parameter int CFG_W     = 32,
  parameter int NAP_BIT   = 9,
  parameter int OUT_W     = 4,
  parameter int TB_W      = 64,
  parameter int DEC_W     = 32,
  parameter int ENTRY_DLY = 4,
  parameter int WAKE_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             periph_nap_prog,
  input  logic             buf_empty,
  input  logic [OUT_W-1:0] outstanding,
  input  logic             irq,
  input  logic             mcheck,
  input  logic             smi,
  input  logic             periph_release,
  input  logic             dec_wr,
  input  logic [DEC_W-1:0] dec_wdata,
  output logic             nap_req,
  output logic             quiesce_ack,
  output logic             snoop_en,
  output logic             core_clk_en,
  output logic [2:0]       state_o,
  output logic             nap_en_o,
  output logic [TB_W-1:0]  tb_o,
  output logic [DEC_W-1:0] dec_o
);
  generate
    if (WAKE_CYC < 1 || WAKE_CYC > 3) begin : g_bad_wake
      $error("WAKE_CYC must lie in 1..3 to meet the four-cycle return");
    end
    if (ENTRY_DLY < 1) begin : g_bad_entry
      $error("ENTRY_DLY must be at least 1");
    end
    if (NAP_BIT >= CFG_W) begin : g_bad_bit
      $error("NAP_BIT outside configuration word");
    end
  endgenerate

  nap_state_e state_w;
  logic       in_full_w;
  logic       dec_exp_w;
  logic       wake_w;
  logic       clear_w;
  logic       nap_en_w;

  assign in_full_w = (state_w == ST_FULL_ON);
  assign wake_w    = irq | mcheck | smi | periph_release | dec_exp_w;

  nap_timebase #(.TB_W(TB_W), .DEC_W(DEC_W)) u_tb (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_load     (dec_wr && in_full_w),
    .dec_load_val (dec_wdata),
    .tb_o         (tb_o),
    .dec_o        (dec_o),
    .dec_expire_o (dec_exp_w)
  );

  nap_enable_reg #(.CFG_W(CFG_W), .NAP_BIT(NAP_BIT)) u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_allowed (in_full_w),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .clear      (clear_w),
    .nap_en_o   (nap_en_w)
  );

  nap_fsm #(.OUT_W(OUT_W), .ENTRY_DLY(ENTRY_DLY), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .soft_rst        (soft_rst),
    .nap_en          (nap_en_w),
    .periph_nap_prog (periph_nap_prog),
    .buf_empty       (buf_empty),
    .outstanding     (outstanding),
    .wake            (wake_w),
    .state_o         (state_w),
    .clear_en_o      (clear_w)
  );

  assign state_o     = state_w;
  assign nap_en_o    = nap_en_w;
  assign nap_req     = (state_w == ST_REQUEST) || (state_w == ST_DRAIN);
  assign quiesce_ack = (state_w == ST_ACK_DLY) || (state_w == ST_NAP);
  assign snoop_en    = in_full_w || nap_req;
  assign core_clk_en = (state_w != ST_NAP);
endmodule

// File: rtl/nap_sequencer_checker.sv
module nap_sequencer_checker #(
  parameter int OUT_W = 4,
  parameter int TB_W  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             irq,
  input logic             mcheck,
  input logic             smi,
  input logic             periph_release,
  input logic             dec_exp,
  input logic             buf_empty,
  input logic [OUT_W-1:0] outstanding,
  input logic [2:0]       state_o,
  input logic             nap_en_o,
  input logic             quiesce_ack,
  input logic             snoop_en,
  input logic             core_clk_en,
  input logic [TB_W-1:0]  tb_o
);
  logic any_wake;
  assign any_wake = irq | mcheck | smi | periph_release | dec_exp;

  assert_stay_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && !nap_en_o) |=> state_o == 3'd0);

  assert_drain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && !(buf_empty && outstanding == '0) && !any_wake && !soft_rst)
      |=> (state_o == 3'd2 && !quiesce_ack));

  assert_ack_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quiesce_ack) |-> (state_o == 3'd3 && $past(state_o) == 3'd2));

  assert_nap_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd4 |-> (quiesce_ack && !snoop_en && !core_clk_en));

  assert_nap_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && any_wake && !soft_rst) |=> (state_o == 3'd5 && !quiesce_ack && core_clk_en));

  assert_entry_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd1 || state_o == 3'd2) && any_wake && !soft_rst)
      |=> (state_o == 3'd0 && !quiesce_ack));

  assert_wake_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd5 |-> !nap_en_o);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (state_o == 3'd0 && !nap_en_o && !quiesce_ack));

  assert_tb_counts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tb_o == $past(tb_o) + TB_W'(1));
endmodule

bind nap_sequencer nap_sequencer_checker #(.OUT_W(OUT_W), .TB_W(TB_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .soft_rst       (soft_rst),
  .irq            (irq),
  .mcheck         (mcheck),
  .smi            (smi),
  .periph_release (periph_release),
  .dec_exp        (dec_exp_w),
  .buf_empty      (buf_empty),
  .outstanding    (outstanding),
  .state_o        (state_o),
  .nap_en_o       (nap_en_o),
  .quiesce_ack    (quiesce_ack),
  .snoop_en       (snoop_en),
  .core_clk_en    (core_clk_en),
  .tb_o           (tb_o)
);

// File: tb/nap_sequencer_tb.sv
module nap_sequencer_tb;
  localparam int CFG_W = 32;
  localparam int NAP_BIT = 9;
  localparam int OUT_W = 4;
  localparam int TB_W = 64;
  localparam int DEC_W = 32;
  localparam int ENTRY_DLY = 4;
  localparam int WAKE_CYC = 3;

  logic clk, rst_n, soft_rst, cfg_wr;
  logic [CFG_W-1:0] cfg_wdata;
  logic periph_nap_prog, buf_empty;
  logic [OUT_W-1:0] outstanding;
  logic irq, mcheck, smi, periph_release, dec_wr;
  logic [DEC_W-1:0] dec_wdata;
  logic nap_req, quiesce_ack, snoop_en, core_clk_en, nap_en_o;
  logic [2:0] state_o;
  logic [TB_W-1:0] tb_o;
  logic [DEC_W-1:0] dec_o;

  int checks = 0;
  int errors = 0;

  nap_sequencer #(.CFG_W(CFG_W), .NAP_BIT(NAP_BIT), .OUT_W(OUT_W), .TB_W(TB_W),
                  .DEC_W(DEC_W), .ENTRY_DLY(ENTRY_DLY), .WAKE_CYC(WAKE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .periph_nap_prog(periph_nap_prog), .buf_empty(buf_empty), .outstanding(outstanding),
    .irq(irq), .mcheck(mcheck), .smi(smi), .periph_release(periph_release),
    .dec_wr(dec_wr), .dec_wdata(dec_wdata), .nap_req(nap_req), .quiesce_ack(quiesce_ack),
    .snoop_en(snoop_en), .core_clk_en(core_clk_en), .state_o(state_o),
    .nap_en_o(nap_en_o), .tb_o(tb_o), .dec_o(dec_o));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic en);
    cfg_wdata = '1;
    cfg_wdata[NAP_BIT] = en;
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic set_wake(input int src, input logic v);
    case (src)
      0: irq = v;
      1: mcheck = v;
      2: smi = v;
      default: periph_release = v;
    endcase
  endtask

  task automatic enter_nap();
    periph_nap_prog = 1'b1; buf_empty = 1'b1; outstanding = '0;
    write_cfg(1'b1);
    repeat (3 + ENTRY_DLY) tick();
    chk("R5 reached NAP", 64'(state_o), 64'd4);
  endtask

  task automatic t_reset();
    chk("R1 state", 64'(state_o), 64'd0);
    chk("R1 ack", 64'(quiesce_ack), 64'd0);
    chk("R1 req", 64'(nap_req), 64'd0);
    chk("R1 snoop", 64'(snoop_en), 64'd1);
    chk("R1 clk_en", 64'(core_clk_en), 64'd1);
    chk("R1 nap_en", 64'(nap_en_o), 64'd0);
    chk("R1 dec", 64'(dec_o), 64'(32'hFFFF_FFFE));
  endtask

  task automatic t_no_enable();
    write_cfg(1'b0);
    repeat (3) tick();
    chk("R2 disabled stays FULL_ON", 64'(state_o), 64'd0);
    chk("R2 no request", 64'(nap_req), 64'd0);
  endtask

  task automatic t_full_cycle(input int src);
    logic [TB_W-1:0] tb_s;
    logic [DEC_W-1:0] dec_s;
    periph_nap_prog = 1'b0; buf_empty = 1'b0; outstanding = 4'd3;
    write_cfg(1'b1);
    chk("R2 bit set", 64'(nap_en_o), 64'd1);
    tick();
    chk("R2 request state", 64'(state_o), 64'd1);
    chk("R2 nap_req", 64'(nap_req), 64'd1);
    repeat (3) tick();
    chk("R3 waits for programming", 64'(state_o), 64'd1);
    periph_nap_prog = 1'b1;
    tick();
    chk("R3 drain state", 64'(state_o), 64'd2);
    repeat (3) tick();
    chk("R4 holds while busy", 64'(state_o), 64'd2);
    chk("R4 ack low", 64'(quiesce_ack), 64'd0);
    buf_empty = 1'b1;
    tick();
    chk("R4 holds with outstanding", 64'(state_o), 64'd2);
    outstanding = '0;
    tick();
    chk("R5 ack delay state", 64'(state_o), 64'd3);
    chk("R5 ack high", 64'(quiesce_ack), 64'd1);
    chk("R5 snoop off", 64'(snoop_en), 64'd0);
    repeat (ENTRY_DLY - 1) begin
      tick();
      chk("R5 still in ack delay", 64'(state_o), 64'd3);
      chk("R6 ack held", 64'(quiesce_ack), 64'd1);
    end
    tick();
    chk("R5 nap state", 64'(state_o), 64'd4);
    chk("R5 clock gated", 64'(core_clk_en), 64'd0);
    dec_s = dec_o;
    dec_wdata = 32'd5; dec_wr = 1'b1;
    write_cfg(1'b0);
    dec_wr = 1'b0;
    chk("R12 load ignored in nap", 64'(dec_o), 64'(dec_s - 32'd1));
    chk("R2 write ignored in nap", 64'(nap_en_o), 64'd1);
    tb_s = tb_o;
    repeat (5) tick();
    chk("R11 tb counts in nap", tb_o, tb_s + 64'd5);
    chk("R6 ack held in nap", 64'(quiesce_ack), 64'd1);
    set_wake(src, 1'b1);
    tick();
    set_wake(src, 1'b0);
    chk("R7 wake state", 64'(state_o), 64'd5);
    chk("R7 ack dropped", 64'(quiesce_ack), 64'd0);
    chk("R7 clock on", 64'(core_clk_en), 64'd1);
    chk("R9 enable cleared", 64'(nap_en_o), 64'd0);
    repeat (WAKE_CYC - 1) tick();
    chk("R7 still waking", 64'(state_o), 64'd5);
    tick();
    chk("R7 full power by fourth edge", 64'(state_o), 64'd0);
    chk("R7 snoop back", 64'(snoop_en), 64'd1);
    tick();
    chk("R9 no re-entry", 64'(state_o), 64'd0);
  endtask

  task automatic t_abort();
    periph_nap_prog = 1'b0;
    write_cfg(1'b1);
    tick();
    chk("R8 in request", 64'(state_o), 64'd1);
    irq = 1'b1;
    tick();
    irq = 1'b0;
    chk("R8 abort from request", 64'(state_o), 64'd0);
    chk("R8 ack low", 64'(quiesce_ack), 64'd0);
    chk("R9 cleared on abort", 64'(nap_en_o), 64'd0);
    periph_nap_prog = 1'b1; buf_empty = 1'b0;
    write_cfg(1'b1);
    repeat (2) tick();
    chk("R8 in drain", 64'(state_o), 64'd2);
    smi = 1'b1;
    tick();
    smi = 1'b0;
    chk("R8 abort from drain", 64'(state_o), 64'd0);
    chk("R8 ack never raised", 64'(quiesce_ack), 64'd0);
    buf_empty = 1'b1;
  endtask

  task automatic t_dec_wake();
    int n;
    periph_nap_prog = 1'b1; buf_empty = 1'b1; outstanding = '0;
    dec_wdata = 32'd30; dec_wr = 1'b1;
    write_cfg(1'b1);
    dec_wr = 1'b0;
    chk("R12 load in FULL_ON", 64'(dec_o), 64'd30);
    tick();
    chk("R12 counts down", 64'(dec_o), 64'd29);
    n = 0;
    while (state_o != 3'd5 && n < 60) begin
      tick();
      n++;
      if (state_o == 3'd4) chk("R6 ack during dec nap", 64'(quiesce_ack), 64'd1);
    end
    chk("R12 expiry woke core", 64'(state_o), 64'd5);
    chk("R12 wrapped value", 64'(dec_o), 64'(32'hFFFF_FFFE));
    repeat (WAKE_CYC) tick();
    chk("R7 back after dec wake", 64'(state_o), 64'd0);
  endtask

  task automatic t_soft();
    logic [TB_W-1:0] tb_s;
    enter_nap();
    tb_s = tb_o;
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    chk("R10 full on", 64'(state_o), 64'd0);
    chk("R10 ack low", 64'(quiesce_ack), 64'd0);
    chk("R10 enable cleared", 64'(nap_en_o), 64'd0);
    chk("R10 tb kept running", tb_o, tb_s + 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
    periph_nap_prog = 1'b0; buf_empty = 1'b1; outstanding = '0;
    irq = 1'b0; mcheck = 1'b0; smi = 1'b0; periph_release = 1'b0;
    dec_wr = 1'b0; dec_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 dec reset value", 64'(dec_o), 64'(32'hFFFF_FFFF));
    rst_n = 1'b1;
    tick();
    t_reset();
    t_no_enable();
    for (int s = 0; s < 4; s++) t_full_cycle(s);
    t_abort();
    t_dec_wake();
    t_soft();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule